// File: doc/BRIEF.md
# Indirect Store Address Generator

This unit sits in the decode stage of a small processor core. It recognises the store instructions that take their address from the X or Y pointer pair. For each one it works out the data-space byte address, the index of the register that supplies the store data, and the new value of the pointer. The core feeds it a 16-bit instruction word with a valid strobe, the current X and Y pointers, an extension byte for each pointer, and a selector for the size of the data space. All results are registered and appear one clock after the instruction is presented.

Four addressing behaviours are covered: the pointer is left as it is, the pointer is incremented after the access, the pointer is decremented before the access, or Y has a 6-bit unsigned offset added to it for the access only. The space selector sets how far the pointer arithmetic carries. In the small space only the low pointer byte changes. In the normal space the full 16 bits wrap. In the extended space the pointer and its extension byte form one 24-bit value. Two things are reported beside the address: a flag for update-mode stores whose source register is a byte of the pointer being updated, and the number of execution cycles the form takes.

Top module: `indirect_store_agu`

## Requirements
- R1: Words `1001 001r rrrr 1100`, `1101` and `1110` (bits 15:0) are X-pointer stores in plain, post-increment and pre-decrement mode. `srcReg` takes bits 8:4 and `ptrSel` is 0. All outputs are registered one clock after a cycle with `instrValid` high.
- R2: Words `1001 001r rrrr 1001` and `1001 001r rrrr 1010` are Y-pointer stores in post-increment and pre-decrement mode, with `ptrSel` set to 1.
- R3: A word matching `10q0 qq1r rrrr 1qqq` is a Y store at Y+q. Here q = {bit13, bits 11:10, bits 2:0}, in the range 0..63, and `ptrWe` stays 0. When q is 0 the word is a plain Y store.
- R4: Post-increment stores at the old pointer value, with `ptrWe`=1 and `ptrNew` = old + 1.
- R5: Pre-decrement stores at old - 1, and `ptrNew` carries that same value with `ptrWe`=1.
- R6: With `spaceSel`=00 (small space), arithmetic acts on the low pointer byte only and wraps in 8 bits. `storeAddr` is that byte zero-extended, and `ptrNew[15:8]` equals the old high byte.
- R7: With `spaceSel`=01 (normal space), arithmetic wraps in 16 bits, `storeAddr[23:16]` is 0, and `extWe` is 0.
- R8: With `spaceSel[1]`=1 (extended space), arithmetic acts on the 24-bit value {extension byte, pointer}, and carries and borrows reach the extension byte. On an update store `extWe`=1 and `extNew` holds the new extension byte.
- R9: `undefFlag` is 1 when a post-increment or pre-decrement store names its own pointer as the source: r26 or r27 for X, r28 or r29 for Y. In every other case it is 0. The store itself is still issued.
- R10: `cycles` is 1 for plain and post-increment stores, 2 for pre-decrement and for displacement with q ≠ 0, and 0 when no store is issued.
- R11: A word that matches no pattern above, or a cycle with `instrValid` low, gives `storeReq`, `ptrWe`, `extWe` and `undefFlag` all equal to 0 on the next clock.
- R12: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| spaceSel | input | 2 | 00 small, 01 normal, 1x extended data space |
| ptrX | input | 16 | Current X pointer |
| ptrY | input | 16 | Current Y pointer |
| extX | input | 8 | Extension byte of X |
| extY | input | 8 | Extension byte of Y |
| storeReq | output | 1 | A store is issued |
| storeAddr | output | 24 | Data-space byte address |
| srcReg | output | 5 | Source register index |
| ptrSel | output | 1 | Pointer written back: 0 X, 1 Y |
| ptrWe | output | 1 | Pointer write-back enable |
| ptrNew | output | 16 | New pointer value |
| extWe | output | 1 | Extension byte write-back enable |
| extNew | output | 8 | New extension byte |
| cycles | output | 2 | Execution cycle count of the store |
| undefFlag | output | 1 | Undefined pointer/source combination |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. Enables are nested: a write-back needs a store, an extension write needs a pointer write, and the flag appears only with a write-back. The cycle count stays within its legal values. Each pre-decrement write-back matches its address in the low byte, and each post-increment write-back is one above it. Exact values are left to the bench's scenarios: opcode bit positions, the scattered displacement bits, carry and borrow behaviour for each space size, preservation of the high byte, and the undefined-register cases at their boundaries.

// File: rtl/stagu_pkg.sv
package stagu_pkg;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       hit;      // word is a supported store form
    logic       useY;     // Y pointer (else X)
    logic       postInc;  // add one after the access
    logic       preDec;   // subtract one before the access
    logic       addDisp;  // add displacement for the access only
    logic [5:0] disp;     // displacement value
    logic [4:0] srcReg;   // data source register
    logic       undef;    // pointer byte used as source in update mode
    logic [1:0] cycles;   // execution cycles
  } ctrlStrobe_t;

  localparam logic [1:0] SPACE_SMALL  = 2'b00;
  localparam logic [1:0] SPACE_NORMAL = 2'b01;

endpackage

// File: rtl/stagu_decode.sv
module stagu_decode
  import stagu_pkg::*;
(
  input  logic [15:0]  instr,
  output ctrlStrobe_t  ctrl
);

  logic ptrHead;
  logic dispForm;
  logic [5:0] qVal;

  assign ptrHead  = (instr[15:9] == 7'b1001001);
  assign dispForm = (instr[15:14] == 2'b10) && !instr[12] && instr[9] && instr[3];
  assign qVal     = {instr[13], instr[11:10], instr[2:0]};

  always_comb begin
    ctrl        = '0;
    ctrl.srcReg = instr[8:4];
    if (ptrHead) begin
      unique case (instr[3:0])
        4'b1100: begin ctrl.hit = 1'b1; end
        4'b1101: begin ctrl.hit = 1'b1; ctrl.postInc = 1'b1; end
        4'b1110: begin ctrl.hit = 1'b1; ctrl.preDec  = 1'b1; end
        4'b1001: begin ctrl.hit = 1'b1; ctrl.useY = 1'b1; ctrl.postInc = 1'b1; end
        4'b1010: begin ctrl.hit = 1'b1; ctrl.useY = 1'b1; ctrl.preDec  = 1'b1; end
        default: ctrl.hit = 1'b0;
      endcase
    end else if (dispForm) begin
      ctrl.hit     = 1'b1;
      ctrl.useY    = 1'b1;
      ctrl.disp    = qVal;
      ctrl.addDisp = (qVal != 6'd0);
    end

    if (ctrl.hit)
      ctrl.cycles = (ctrl.preDec || ctrl.addDisp) ? 2'd2 : 2'd1;

    // own-pointer source in update mode: r26/r27 for X, r28/r29 for Y
    ctrl.undef = ctrl.hit && (ctrl.postInc || ctrl.preDec) &&
                 (ctrl.srcReg[4:1] == (ctrl.useY ? 4'b1110 : 4'b1101));
  end

endmodule

// File: rtl/stagu_datapath.sv
module stagu_datapath
  import stagu_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  ctrlStrobe_t        ctrl,
  input  logic [1:0]         spaceSel,
  input  logic [PTR_W-1:0]   ptrX,
  input  logic [PTR_W-1:0]   ptrY,
  input  logic [EXT_W-1:0]   extX,
  input  logic [EXT_W-1:0]   extY,
  output logic               storeReq,
  output logic [PTR_W+EXT_W-1:0] storeAddr,
  output logic [4:0]         srcReg,
  output logic               ptrSel,
  output logic               ptrWe,
  output logic [PTR_W-1:0]   ptrNew,
  output logic               extWe,
  output logic [EXT_W-1:0]   extNew,
  output logic [1:0]         cycles,
  output logic               undefFlag
);

  localparam int FULL_W  = PTR_W + EXT_W;
  localparam int SMALL_W = 8;

  logic [PTR_W-1:0]  basePtr;
  logic [EXT_W-1:0]  baseExt;
  logic [FULL_W-1:0] baseFull, addrOff, updOff, addrSum, updSum;
  logic [FULL_W-1:0] addrNext;
  logic [PTR_W-1:0]  ptrNext;
  logic [EXT_W-1:0]  extNext;
  logic              isSmall, isNormal, isExt, fire, update;

  assign basePtr  = ctrl.useY ? ptrY : ptrX;
  assign baseExt  = ctrl.useY ? extY : extX;
  assign baseFull = {baseExt, basePtr};
  assign isSmall  = (spaceSel == SPACE_SMALL);
  assign isNormal = (spaceSel == SPACE_NORMAL);
  assign isExt    = spaceSel[1];
  assign fire     = instrValid && ctrl.hit;
  assign update   = ctrl.postInc || ctrl.preDec;

  always_comb begin
    addrOff = '0;
    if (ctrl.preDec)       addrOff = '1;
    else if (ctrl.addDisp) addrOff = {{(FULL_W-6){1'b0}}, ctrl.disp};
    updOff = '0;
    if (ctrl.postInc)      updOff = {{(FULL_W-1){1'b0}}, 1'b1};
    else if (ctrl.preDec)  updOff = '1;
  end

  assign addrSum = baseFull + addrOff;
  assign updSum  = baseFull + updOff;

  // Space size picks how far the arithmetic reaches
  always_comb begin
    if (isSmall) begin
      addrNext = {{(FULL_W-SMALL_W){1'b0}}, addrSum[SMALL_W-1:0]};
      ptrNext  = {basePtr[PTR_W-1:SMALL_W], updSum[SMALL_W-1:0]};
      extNext  = baseExt;
    end else if (isNormal) begin
      addrNext = {{EXT_W{1'b0}}, addrSum[PTR_W-1:0]};
      ptrNext  = updSum[PTR_W-1:0];
      extNext  = baseExt;
    end else begin
      addrNext = addrSum;
      ptrNext  = updSum[PTR_W-1:0];
      extNext  = updSum[FULL_W-1:PTR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !fire) begin
      storeReq  <= 1'b0;
      storeAddr <= '0;
      srcReg    <= '0;
      ptrSel    <= 1'b0;
      ptrWe     <= 1'b0;
      ptrNew    <= '0;
      extWe     <= 1'b0;
      extNew    <= '0;
      cycles    <= '0;
      undefFlag <= 1'b0;
    end else begin
      storeReq  <= 1'b1;
      storeAddr <= addrNext;
      srcReg    <= ctrl.srcReg;
      ptrSel    <= ctrl.useY;
      ptrWe     <= update;
      ptrNew    <= ptrNext;
      extWe     <= update && isExt;
      extNew    <= extNext;
      cycles    <= ctrl.cycles;
      undefFlag <= ctrl.undef;
    end
  end

endmodule

// File: rtl/indirect_store_agu.sv
module indirect_store_agu
  import stagu_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instrValid,
  input  logic [15:0]            instr,
  input  logic [1:0]             spaceSel,
  input  logic [PTR_W-1:0]       ptrX,
  input  logic [PTR_W-1:0]       ptrY,
  input  logic [EXT_W-1:0]       extX,
  input  logic [EXT_W-1:0]       extY,
  output logic                   storeReq,
  output logic [PTR_W+EXT_W-1:0] storeAddr,
  output logic [4:0]             srcReg,
  output logic                   ptrSel,
  output logic                   ptrWe,
  output logic [PTR_W-1:0]       ptrNew,
  output logic                   extWe,
  output logic [EXT_W-1:0]       extNew,
  output logic [1:0]             cycles,
  output logic                   undefFlag
);

  ctrlStrobe_t ctrl;

  stagu_decode u_decode (
    .instr (instr),
    .ctrl  (ctrl)
  );

  stagu_datapath #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .ctrl       (ctrl),
    .spaceSel   (spaceSel),
    .ptrX       (ptrX),
    .ptrY       (ptrY),
    .extX       (extX),
    .extY       (extY),
    .storeReq   (storeReq),
    .storeAddr  (storeAddr),
    .srcReg     (srcReg),
    .ptrSel     (ptrSel),
    .ptrWe      (ptrWe),
    .ptrNew     (ptrNew),
    .extWe      (extWe),
    .extNew     (extNew),
    .cycles     (cycles),
    .undefFlag  (undefFlag)
  );

endmodule

// File: rtl/stagu_checker.sv
module stagu_checker #(
  parameter int PTR_W = 16,
  parameter int EXT_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   instrValid,
  input logic                   storeReq,
  input logic                   ptrWe,
  input logic                   extWe,
  input logic                   undefFlag,
  input logic [1:0]             cycles,
  input logic [PTR_W+EXT_W-1:0] storeAddr,
  input logic [PTR_W-1:0]       ptrNew
);

  a_r11_req_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(instrValid));

  a_r11_wb_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    ptrWe |-> storeReq);

  a_r8_ext_needs_wb: assert property (@(posedge clk) disable iff (!rstN)
    extWe |-> ptrWe);

  a_r9_flag_in_update: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> ptrWe);

  a_r10_cycles_legal: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> (cycles == 2'd1 || cycles == 2'd2));

  a_r10_cycles_idle: assert property (@(posedge clk) disable iff (!rstN)
    !storeReq |-> (cycles == 2'd0));

  a_r5_predec_same: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWe && cycles == 2'd2) |-> (ptrNew[7:0] == storeAddr[7:0]));

  a_r4_postinc_next: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWe && cycles == 2'd1) |-> (ptrNew[7:0] == storeAddr[7:0] + 8'd1));

endmodule

bind indirect_store_agu stagu_checker #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .storeReq   (storeReq),
  .ptrWe      (ptrWe),
  .extWe      (extWe),
  .undefFlag  (undefFlag),
  .cycles     (cycles),
  .storeAddr  (storeAddr),
  .ptrNew     (ptrNew)
);

// File: tb/indirect_store_agu_test.sv
`timescale 1ns/1ps
module indirect_store_agu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instr = '0;
  logic [1:0]  spaceSel = 2'b01;
  logic [15:0] ptrX = '0, ptrY = '0;
  logic [7:0]  extX = '0, extY = '0;
  logic        storeReq, ptrSel, ptrWe, extWe, undefFlag;
  logic [23:0] storeAddr;
  logic [4:0]  srcReg;
  logic [15:0] ptrNew;
  logic [7:0]  extNew;
  logic [1:0]  cycles;

  int runs = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  indirect_store_agu uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .spaceSel(spaceSel), .ptrX(ptrX), .ptrY(ptrY), .extX(extX), .extY(extY),
    .storeReq(storeReq), .storeAddr(storeAddr), .srcReg(srcReg),
    .ptrSel(ptrSel), .ptrWe(ptrWe), .ptrNew(ptrNew), .extWe(extWe),
    .extNew(extNew), .cycles(cycles), .undefFlag(undefFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic [1:0] sp,
                       input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] ex, input logic [7:0] ey);
    @(negedge clk);
    instr = w; spaceSel = sp; ptrX = x; ptrY = y; extX = ex; extY = ey;
    instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic expStore(input string tag, input logic [23:0] addr, input logic [4:0] src,
                          input logic sel, input logic we, input logic [15:0] pn,
                          input logic ewe, input logic [7:0] en, input logic [1:0] cyc,
                          input logic flag);
    chk({tag, " storeReq"}, 32'(storeReq), 32'd1);
    chk({tag, " storeAddr"}, 32'(storeAddr), 32'(addr));
    chk({tag, " srcReg"}, 32'(srcReg), 32'(src));
    chk({tag, " ptrSel"}, 32'(ptrSel), 32'(sel));
    chk({tag, " ptrWe"}, 32'(ptrWe), 32'(we));
    if (we) chk({tag, " ptrNew"}, 32'(ptrNew), 32'(pn));
    chk({tag, " extWe"}, 32'(extWe), 32'(ewe));
    if (ewe) chk({tag, " extNew"}, 32'(extNew), 32'(en));
    chk({tag, " cycles"}, 32'(cycles), 32'(cyc));
    chk({tag, " undefFlag"}, 32'(undefFlag), 32'(flag));
  endtask

  task automatic expIdle(input string tag);
    chk({tag, " storeReq"}, 32'(storeReq), 32'd0);
    chk({tag, " ptrWe"}, 32'(ptrWe), 32'd0);
    chk({tag, " extWe"}, 32'(extWe), 32'd0);
    chk({tag, " undefFlag"}, 32'(undefFlag), 32'd0);
    chk({tag, " cycles"}, 32'(cycles), 32'd0);
  endtask

  task automatic testReset();
    // R12: outputs cleared while reset is held
    @(negedge clk);
    instr = 16'h930D; instrValid = 1'b1;
    @(negedge clk);
    expIdle("R12 reset");
    chk("R12 reset storeAddr", 32'(storeAddr), 32'd0);
    instrValid = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic testXForms();
    // R1 plain X, r5, normal space
    issue(16'h925C, 2'b01, 16'h1234, 16'h0, 8'h0, 8'h0);
    expStore("R1 x plain", 24'h001234, 5'd5, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 2'd1, 1'b0);
    // R1 R4 post-increment X, r16
    issue(16'h930D, 2'b01, 16'h00FF, 16'h0, 8'h0, 8'h0);
    expStore("R4 x post", 24'h0000FF, 5'd16, 1'b0, 1'b1, 16'h0100, 1'b0, 8'h0, 2'd1, 1'b0);
    // R1 R5 pre-decrement X, r3
    issue(16'h923E, 2'b01, 16'h0100, 16'h0, 8'h0, 8'h0);
    expStore("R5 x pre", 24'h0000FF, 5'd3, 1'b0, 1'b1, 16'h00FF, 1'b0, 8'h0, 2'd2, 1'b0);
  endtask

  task automatic testYForms();
    // R2 R4 Y post-increment, r1
    issue(16'h9219, 2'b01, 16'h0, 16'h2000, 8'h0, 8'h0);
    expStore("R2 y post", 24'h002000, 5'd1, 1'b1, 1'b1, 16'h2001, 1'b0, 8'h0, 2'd1, 1'b0);
    // R2 R7 Y pre-decrement wraps in 16 bits, no extension write
    issue(16'h922A, 2'b01, 16'h0, 16'h0000, 8'h0, 8'h33);
    expStore("R7 y pre wrap", 24'h00FFFF, 5'd2, 1'b1, 1'b1, 16'hFFFF, 1'b0, 8'h0, 2'd2, 1'b0);
  endtask

  task automatic testDisp();
    // R3 q=63, r4
    issue(16'hAE4F, 2'b01, 16'h0, 16'h0100, 8'h0, 8'h0);
    expStore("R3 disp 63", 24'h00013F, 5'd4, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0, 2'd2, 1'b0);
    // R3 R10 q=0 is plain Y, one cycle
    issue(16'h8278, 2'b01, 16'h0, 16'h4567, 8'h0, 8'h0);
    expStore("R10 disp zero", 24'h004567, 5'd7, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0, 2'd1, 1'b0);
    // R3 R8 q=32 in extended space carries into extension
    issue(16'hA208, 2'b10, 16'h0, 16'hFFF0, 8'h0, 8'h01);
    expStore("R8 disp ext", 24'h020010, 5'd0, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0, 2'd2, 1'b0);
    // R6 q=32 in small space wraps in low byte
    issue(16'hA208, 2'b00, 16'h0, 16'hAAF0, 8'h0, 8'h0);
    expStore("R6 disp small", 24'h000010, 5'd0, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0, 2'd2, 1'b0);
  endtask

  task automatic testSpaces();
    // R6 small pre-decrement keeps high byte
    issue(16'h923E, 2'b00, 16'h0100, 16'h0, 8'h0, 8'h0);
    expStore("R6 small pre", 24'h0000FF, 5'd3, 1'b0, 1'b1, 16'h01FF, 1'b0, 8'h0, 2'd2, 1'b0);
    // R6 small post-increment wraps low byte
    issue(16'h930D, 2'b00, 16'h12FF, 16'h0, 8'h0, 8'h0);
    expStore("R6 small post", 24'h0000FF, 5'd16, 1'b0, 1'b1, 16'h1200, 1'b0, 8'h0, 2'd1, 1'b0);
    // R8 extended post-increment carries
    issue(16'h930D, 2'b10, 16'hFFFF, 16'h0, 8'h02, 8'h0);
    expStore("R8 ext post", 24'h02FFFF, 5'd16, 1'b0, 1'b1, 16'h0000, 1'b1, 8'h03, 2'd1, 1'b0);
    // R8 extended pre-decrement borrows, selector 11
    issue(16'h923E, 2'b11, 16'h0000, 16'h0, 8'h05, 8'h0);
    expStore("R8 ext pre", 24'h04FFFF, 5'd3, 1'b0, 1'b1, 16'hFFFF, 1'b1, 8'h04, 2'd2, 1'b0);
  endtask

  task automatic testUndef();
    issue(16'h93AD, 2'b01, 16'h0200, 16'h0, 8'h0, 8'h0);
    expStore("R9 x post r26", 24'h000200, 5'd26, 1'b0, 1'b1, 16'h0201, 1'b0, 8'h0, 2'd1, 1'b1);
    issue(16'h93BE, 2'b01, 16'h0200, 16'h0, 8'h0, 8'h0);
    expStore("R9 x pre r27", 24'h0001FF, 5'd27, 1'b0, 1'b1, 16'h01FF, 1'b0, 8'h0, 2'd2, 1'b1);
    issue(16'h93CA, 2'b01, 16'h0, 16'h0300, 8'h0, 8'h0);
    expStore("R9 y pre r28", 24'h0002FF, 5'd28, 1'b1, 1'b1, 16'h02FF, 1'b0, 8'h0, 2'd2, 1'b1);
    issue(16'h93D9, 2'b01, 16'h0, 16'h0300, 8'h0, 8'h0);
    expStore("R9 y post r29", 24'h000300, 5'd29, 1'b1, 1'b1, 16'h0301, 1'b0, 8'h0, 2'd1, 1'b1);
    // boundaries: other pointer's register, and plain mode, give no flag
    issue(16'h93CD, 2'b01, 16'h0200, 16'h0, 8'h0, 8'h0);
    expStore("R9 x post r28", 24'h000200, 5'd28, 1'b0, 1'b1, 16'h0201, 1'b0, 8'h0, 2'd1, 1'b0);
    issue(16'h93AC, 2'b01, 16'h0200, 16'h0, 8'h0, 8'h0);
    expStore("R9 x plain r26", 24'h000200, 5'd26, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 2'd1, 1'b0);
    issue(16'h93B9, 2'b01, 16'h0, 16'h0300, 8'h0, 8'h0);
    expStore("R9 y post r27", 24'h000300, 5'd27, 1'b1, 1'b1, 16'h0301, 1'b0, 8'h0, 2'd1, 1'b0);
  endtask

  task automatic testUnmatched();
    // R11 words outside every store pattern
    issue(16'h0000, 2'b01, 16'h1111, 16'h2222, 8'h0, 8'h0);
    expIdle("R11 zero word");
    issue(16'h9208, 2'b01, 16'h1111, 16'h2222, 8'h0, 8'h0);
    expIdle("R11 head bad tail");
    issue(16'h8200, 2'b01, 16'h1111, 16'h2222, 8'h0, 8'h0);
    expIdle("R11 disp bit3 clear");
    // R11 valid low with a legal word
    @(negedge clk);
    instr = 16'h930D; instrValid = 1'b0;
    @(negedge clk);
    expIdle("R11 valid low");
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    testReset();
    testXForms();
    testYForms();
    testDisp();
    testSpaces();
    testUndef();
    testUnmatched();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule